// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It compares the two source register fields of the instruction in decode against the target register of the instruction one stage ahead. That target register is the load's `rt` field. When the instruction ahead is a memory read whose target is one of those sources, the value cannot reach decode in time, even with forwarding. The unit then requests a stall.

While the stall is raised, the unit drops the write enables of the program counter and of the fetch/decode register, so the consumer is held for one cycle. It also forces the control bundle entering the decode/execute register to all zeros. The slot that follows the load therefore carries a bubble that writes neither the register file nor memory.

Every other dependency is left to the forwarding network. This includes a consumer two slots behind a load, and any producer that is not a load. The unit is purely combinational, so the stall appears in the same cycle as the condition. A load-use pair costs exactly one extra clock. When half of the loads are followed at once by a consumer, loads average 1.5 clocks.

Top module: `lu_stall_unit`

## Requirements
- R1: When `idex_mem_read` is 1 and `idex_rt` is nonzero and equals `ifid_rs`, `stall` is 1 in the same cycle.
- R2: When `idex_mem_read` is 1 and `idex_rt` is nonzero and equals `ifid_rt`, `stall` is 1 in the same cycle.
- R3: When `idex_mem_read` is 0, `stall` is 0 whatever the register fields hold.
- R4: With the default zero-register policy, an `idex_rt` of 0 never raises `stall`, even if a source field is also 0.
- R5: `pc_write_en` and `ifid_write_en` are both 0 exactly while `stall` is 1, and both 1 otherwise.
- R6: While `stall` is 1, `ctrl_out` is all zeros. While `stall` is 0, `ctrl_out` equals `ctrl_in`.
- R7: In a running pipeline, each load followed at once by a consumer of its target inserts exactly one bubble. A consumer two slots after a load, a non-consuming successor, and a load to register 0 insert none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | REG_ADDR_W (5) | First source register of the instruction in decode |
| ifid_rt | input | REG_ADDR_W (5) | Second source register of the instruction in decode |
| idex_rt | input | REG_ADDR_W (5) | Target register field of the instruction in execute |
| idex_mem_read | input | 1 | Instruction in execute reads memory (is a load) |
| ctrl_in | input | CTRL_W (9) | Control bundle decoded for the instruction in decode |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may update |
| ctrl_out | output | CTRL_W (9) | Control bundle to write into the decode/execute register |

## Verification
A wrong comparator or a lost memory-read qualifier shows in the same cycle at `stall`. It also shows at the two write enables and at `ctrl_out`, because the block holds no state that could delay it. Inside a pipeline, such an error appears one clock later as a missing or doubled bubble. That changes the number of cycles needed to issue a fixed instruction stream, so the bench counts stall cycles for each decode slot and the total issue time. A wrong bubble mask shows as nonzero control bits leaking into a stalled slot.

// File: rtl/lu_pkg.sv
package lu_pkg;
   // Policy for a load whose target is register zero
   typedef enum logic {
      ZR_EXEMPT  = 1'b0,
      ZR_COMPARE = 1'b1
   } zr_mode_e;

   localparam int unsigned SRC_COUNT = 2;
endpackage

// File: rtl/lu_reg_match.sv
module lu_reg_match #(
   parameter int unsigned      REG_ADDR_W = 5,
   parameter lu_pkg::zr_mode_e ZERO_MODE  = lu_pkg::ZR_EXEMPT
) (
   input  logic [REG_ADDR_W-1:0] src_reg,
   input  logic [REG_ADDR_W-1:0] dst_reg,
   output logic                  hit
);
   logic same;
   assign same = (src_reg == dst_reg);

   generate
      if (ZERO_MODE == lu_pkg::ZR_EXEMPT) begin : g_exempt
         assign hit = same && (dst_reg != '0);
      end else begin : g_compare
         assign hit = same;
      end
   endgenerate
endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux #(
   parameter int unsigned CTRL_W = 9
) (
   input  logic              kill,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic [CTRL_W-1:0] ctrl_out
);
   always_comb begin
      ctrl_out = ctrl_in;
      if (kill) ctrl_out = '0;
   end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit #(
   parameter int unsigned      REG_ADDR_W = 5,
   parameter int unsigned      CTRL_W     = 9,
   parameter lu_pkg::zr_mode_e ZERO_MODE  = lu_pkg::ZR_EXEMPT
) (
   input  logic [REG_ADDR_W-1:0] ifid_rs,
   input  logic [REG_ADDR_W-1:0] ifid_rt,
   input  logic [REG_ADDR_W-1:0] idex_rt,
   input  logic                  idex_mem_read,
   input  logic [CTRL_W-1:0]     ctrl_in,
   output logic                  stall,
   output logic                  pc_write_en,
   output logic                  ifid_write_en,
   output logic [CTRL_W-1:0]     ctrl_out
);
   localparam int unsigned SRC_N = lu_pkg::SRC_COUNT;

   generate
      if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_addr
         $error("lu_stall_unit: REG_ADDR_W out of range");
      end
      if (CTRL_W < 1) begin : g_bad_ctrl
         $error("lu_stall_unit: CTRL_W must be positive");
      end
   endgenerate

   logic [REG_ADDR_W-1:0] src_vec [SRC_N];
   logic [SRC_N-1:0]      src_hit;
   logic                  hazard;

   assign src_vec[0] = ifid_rs;
   assign src_vec[1] = ifid_rt;

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
         lu_reg_match #(
            .REG_ADDR_W(REG_ADDR_W),
            .ZERO_MODE (ZERO_MODE)
         ) i_match (
            .src_reg(src_vec[s]),
            .dst_reg(idex_rt),
            .hit    (src_hit[s])
         );
      end
   endgenerate

   assign hazard        = idex_mem_read && (|src_hit);
   assign stall         = hazard;
   assign pc_write_en   = ~hazard;
   assign ifid_write_en = ~hazard;

   lu_bubble_mux #(.CTRL_W(CTRL_W)) i_bubble (
      .kill    (hazard),
      .ctrl_in (ctrl_in),
      .ctrl_out(ctrl_out)
   );

   always_comb begin
      // R3
      stall_needs_load_chk: assert (!stall || idex_mem_read);
      // R1 R2
      stall_needs_match_chk: assert (!stall || ifid_rs == idex_rt || ifid_rt == idex_rt);
      // R5
      we_pair_chk: assert (pc_write_en == ifid_write_en && pc_write_en != stall);
      // R6
      bubble_zero_chk: assert (!stall || ctrl_out == '0);
      // R6
      pass_through_chk: assert (stall || ctrl_out == ctrl_in);
   end

   generate
      if (ZERO_MODE == lu_pkg::ZR_EXEMPT) begin : g_zero_chk
         always_comb begin
            // R4
            zero_dest_chk: assert (!stall || idex_rt != '0);
         end
      end
   endgenerate
endmodule

// File: tb/test_lu_stall_unit.sv
module test_lu_stall_unit;
   localparam int W = 5;
   localparam int C = 9;
   localparam int N = 9;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] ifid_rs, ifid_rt, idex_rt;
   logic         idex_mem_read;
   logic [C-1:0] ctrl_in;
   logic         stall, pc_write_en, ifid_write_en;
   logic [C-1:0] ctrl_out;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   lu_stall_unit i_lu_stall_unit (
      .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .idex_rt(idex_rt),
      .idex_mem_read(idex_mem_read), .ctrl_in(ctrl_in),
      .stall(stall), .pc_write_en(pc_write_en),
      .ifid_write_en(ifid_write_en), .ctrl_out(ctrl_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input int rs, input int rt, input int drt, input bit mr, input int ci);
      @(negedge clk);
      ifid_rs = W'(rs); ifid_rt = W'(rt); idex_rt = W'(drt);
      idex_mem_read = mr; ctrl_in = C'(ci);
      #2;
   endtask

   task automatic t_idle;
      apply(0, 0, 0, 0, 0);
      check("R3 idle stall", stall, 0);
      check("R5 idle pc_we", pc_write_en, 1);
      check("R5 idle ifid_we", ifid_write_en, 1);
   endtask

   task automatic t_rs_match;
      apply(7, 3, 7, 1, 'h1A5);
      check("R1 rs stall", stall, 1);
      check("R5 rs pc_we", pc_write_en, 0);
      check("R5 rs ifid_we", ifid_write_en, 0);
      check("R6 rs bubble", ctrl_out, 0);
   endtask

   task automatic t_rt_match;
      apply(4, 31, 31, 1, 'h0FF);
      check("R2 rt stall", stall, 1);
      check("R6 rt bubble", ctrl_out, 0);
      apply(4, 30, 31, 1, 'h0FF);
      check("R2 near miss stall", stall, 0);
      check("R6 near miss pass", ctrl_out, 'h0FF);
   endtask

   task automatic t_no_load;
      apply(9, 9, 9, 0, 'h155);
      check("R3 no load stall", stall, 0);
      check("R6 no load pass", ctrl_out, 'h155);
   endtask

   task automatic t_zero_dest;
      apply(0, 0, 0, 1, 'h1FF);
      check("R4 zero dest stall", stall, 0);
      check("R4 zero dest pass", ctrl_out, 'h1FF);
      check("R5 zero dest pc_we", pc_write_en, 1);
   endtask

   // R7: instruction stream through a modelled IF/ID and ID/EX pair
   task automatic t_stream;
      bit       p_ld [N];
      int       p_rs [N];
      int       p_rt [N];
      int       stalls_at [N];
      int       ifid_idx = 0;
      bit       x_mr = 0;
      int       x_rt = 0;
      int       cycles = 0;
      int       bubble_leak = 0;
      // lw r2 / and r4,r1,r5 / or r8,r2,r6 / lw r3 / add r7,r3,r1 /
      // lw r9 / sub r10,r1,r9 / lw r0 / add r1,r0,r0
      p_ld = '{1,0,0,1,0,1,0,1,0};
      p_rs = '{1,1,2,1,3,1,1,1,0};
      p_rt = '{2,5,6,3,1,9,9,0,0};
      for (int i = 0; i < N; i++) stalls_at[i] = 0;
      while (ifid_idx < N) begin
         apply(p_rs[ifid_idx], p_rt[ifid_idx], x_rt, x_mr, 'h100 | ifid_idx);
         cycles++;
         if (stall) begin
            stalls_at[ifid_idx]++;
            if (ctrl_out != 0) bubble_leak++;
            x_mr = 0; x_rt = 0;
         end else begin
            x_mr = p_ld[ifid_idx];
            x_rt = p_rt[ifid_idx];
            ifid_idx++;
         end
      end
      check("R7 slot1 no use", stalls_at[1], 0);
      check("R7 slot2 two later", stalls_at[2], 0);
      check("R7 slot4 rs use one bubble", stalls_at[4], 1);
      check("R7 slot6 rt use one bubble", stalls_at[6], 1);
      check("R7 slot8 zero dest", stalls_at[8], 0);
      check("R7 load slots", stalls_at[0] + stalls_at[3] + stalls_at[5] + stalls_at[7], 0);
      check("R7 issue cycles", cycles, N + 2);
      check("R6 stream bubble clean", bubble_leak, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      ifid_rs = '0; ifid_rt = '0; idex_rt = '0; idex_mem_read = 0; ctrl_in = '0;
      repeat (2) @(posedge clk);
      t_idle;
      t_rs_match;
      t_rt_match;
      t_no_load;
      t_zero_dest;
      t_stream;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule